// File: doc/BRIEF.md
# Raster Timing Controller with Byte Register Bank

This block is the sync and blanking source of a framebuffer display. A host programs a bank of sixteen byte-wide registers over a simple synchronous byte bus. From those values a character-granular raster engine produces the following outputs:

- horizontal sync, vertical sync and composite sync;
- a blanking level;
- a cursor-window strobe;
- a transfer-holdoff window;
- an interrupt at the start of every vertical blanking interval.

A single control byte switches the timing engine, the video output, the cursor strobe and the interrupt independently. It also carries a four-bit clock-select code for an external clock synthesiser. A read-only status byte reports the monitor sense code, the resolution code and the pending interrupt. The monitor sense pins are captured once after reset.

Horizontal values count characters, and each character is `CHAR_W` pixel clocks. Vertical values count lines. Blanking begins at a programmed start point, and the line or frame ends a programmed number of units later. Sync edges are offsets measured from the start of blanking.

Top module: `raster_timing_ctrl`

## Requirements
- R1: The register bank sits at byte offsets REG_BASE+0 to REG_BASE+15 (0x10 to 0x1F by default). Offset 0 is control and offset 1 is status. Offsets 2 and 3 are the cursor window first and end character. Offsets 4 to 15 are, in order: h-blank start, h-blank length, h-sync start offset, h-sync end offset, composite-sync end offset, v-blank start high byte, v-blank start low byte, v-blank length, v-sync start offset, v-sync end offset, holdoff first character and holdoff end character. Every offset except status reads back the last byte written. Addresses outside the bank read 0 and ignore writes.
- R2: The status byte reads {pending, resolution[2:0], monitor id[3:0]} with the pending flag in bit 7. The resolution and id fields are sampled from the monRes/monId pins on the first clock after reset. Later pin changes and bus writes leave these fields unchanged.
- R3: After reset every register reads 0. blank is 1, and hSync, vSync, compSync and irq are 0.
- R4: While control bit 5 (timing enable) is 0, the counters hold at character 0 of line 0. hSync, vSync, compSync, cursorHit and xferHold are 0, and blank is 1. When bit 5 is set, the raster starts from character 0 of line 0.
- R5: A line lasts hBlankStart + hBlankLen characters of CHAR_W clocks each. Horizontal blanking covers characters at or beyond hBlankStart. hSync is high where the offset from hBlankStart lies in [hSyncStart, hSyncEnd).
- R6: The vertical blank start is the 16-bit value {high byte, low byte}. A frame lasts vBlankStart + vBlankLen lines. Vertical blanking covers lines at or beyond vBlankStart. vSync is high where the line offset from vBlankStart lies in [vSyncStart, vSyncEnd).
- R7: blank is 1 during horizontal or vertical blanking, or whenever control bit 6 (video enable) is 0. Clearing bit 6 leaves the other control bits and the running raster untouched.
- R8: The pending flag sets on the clock edge where the raster enters line vBlankStart, provided control bit 7 (interrupt enable) is 1. irq is pending AND bit 7. Any write to the status offset clears the flag, and this clear takes priority over a set in the same cycle.
- R9: Outside vSync lines, compSync equals hSync. On vSync lines, compSync is 1 except in the horizontal blank offsets [hSyncStart, compSyncEnd).
- R10: cursorHit is 1 when control bit 4 (cursor enable) is 1, the raster is outside both blankings, and the character lies in [cursorFirst, cursorEnd).
- R11: xferHold is 1 while the raster runs and the character lies in [holdoffFirst, holdoffEnd).
- R12: clkSel outputs control bits 3:0, with the crystal select in bits 3:2 and the divisor in bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Byte address |
| busWe | input | 1 | Write strobe, one byte per cycle |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for busAddr, combinational |
| monId | input | 4 | Static monitor id pins |
| monRes | input | 3 | Static resolution code pins |
| hSync | output | 1 | Horizontal sync |
| vSync | output | 1 | Vertical sync |
| compSync | output | 1 | Composite sync |
| blank | output | 1 | Blanking, 1 = blanked |
| cursorHit | output | 1 | Cursor window strobe |
| xferHold | output | 1 | Transfer-holdoff window |
| irq | output | 1 | Vertical-blank interrupt |
| clkSel | output | 4 | Crystal and divisor select |

## Verification
The bench builds the block with CHAR_W = 2 and keeps the default five-bit address bus with the bank at 0x10. It programs a 14-character line and a 9-line frame. This makes a whole frame only 252 clocks long, so two complete frames, including the frame wrap and a repeated vertical-blank entry, are compared sample by sample against a model of the requirements. The short character also allows a second run with the vertical start high byte set, which reaches a 256-line boundary in a few thousand cycles.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int NUM_REGS = 16;

  localparam int IDX_CTRL   = 0;
  localparam int IDX_STATUS = 1;
  localparam int IDX_CURF   = 2;
  localparam int IDX_CURE   = 3;
  localparam int IDX_HBS    = 4;
  localparam int IDX_HBL    = 5;
  localparam int IDX_HSS    = 6;
  localparam int IDX_HSE    = 7;
  localparam int IDX_CSE    = 8;
  localparam int IDX_VBSH   = 9;
  localparam int IDX_VBSL   = 10;
  localparam int IDX_VBL    = 11;
  localparam int IDX_VSS    = 12;
  localparam int IDX_VSE    = 13;
  localparam int IDX_XHF    = 14;
  localparam int IDX_XHE    = 15;

  // control-byte bit positions
  localparam int BIT_INT   = 7;
  localparam int BIT_VIDEO = 6;
  localparam int BIT_RUN   = 5;
  localparam int BIT_CURS  = 4;

  // strobes from the register control to the raster datapath
  typedef struct packed {
    logic runEn;
    logic videoEn;
    logic cursorEn;
  } rtc_ctl_t;

  typedef struct packed {
    logic [7:0]  curFirst;
    logic [7:0]  curEnd;
    logic [7:0]  hBlankStart;
    logic [7:0]  hBlankLen;
    logic [7:0]  hSyncStart;
    logic [7:0]  hSyncEnd;
    logic [7:0]  compSyncEnd;
    logic [15:0] vBlankStart;
    logic [7:0]  vBlankLen;
    logic [7:0]  vSyncStart;
    logic [7:0]  vSyncEnd;
    logic [7:0]  holdFirst;
    logic [7:0]  holdEnd;
  } rtc_cfg_t;

endpackage

// File: rtl/rtc_regs.sv
module rtc_regs
  import rtc_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int REG_BASE = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  input  logic [3:0]        monId,
  input  logic [2:0]        monRes,
  input  logic              vbEnter,
  output rtc_ctl_t          ctl,
  output rtc_cfg_t          cfg,
  output logic [3:0]        clkSel,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(REG_BASE);
  localparam logic [ADDR_W-1:0] SPAN_A = ADDR_W'(NUM_REGS);

  logic [7:0]        regQ [NUM_REGS];
  logic [ADDR_W-1:0] offs;
  logic [3:0]        idx;
  logic              hit;
  logic              statusWr;
  logic              pendQ;
  logic              monTaken;
  logic [6:0]        monQ;
  logic [7:0]        statusByte;

  assign offs     = busAddr - BASE_A;
  assign idx      = offs[3:0];
  assign hit      = (busAddr >= BASE_A) && (offs < SPAN_A);
  assign statusWr = busWe && hit && (idx == 4'(IDX_STATUS));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regQ[i] <= 8'h00;
    end else if (busWe && hit) begin
      for (int i = 0; i < NUM_REGS; i++)
        if (i != IDX_STATUS && idx == 4'(i)) regQ[i] <= busWdata;
    end
  end

  // monitor sense captured once, on the first clock after reset
  always_ff @(posedge clk) begin
    if (!rstN) begin
      monTaken <= 1'b0;
      monQ     <= 7'h00;
    end else if (!monTaken) begin
      monTaken <= 1'b1;
      monQ     <= {monRes, monId};
    end
  end

  // pending flag: a status write wins over a new vertical-blank entry
  always_ff @(posedge clk) begin
    if (!rstN)                              pendQ <= 1'b0;
    else if (statusWr)                      pendQ <= 1'b0;
    else if (vbEnter && regQ[IDX_CTRL][BIT_INT]) pendQ <= 1'b1;
  end

  assign statusByte = {pendQ, monQ};

  always_comb begin
    if (!hit)                       busRdata = 8'h00;
    else if (idx == 4'(IDX_STATUS)) busRdata = statusByte;
    else                            busRdata = regQ[idx];
  end

  assign ctl.runEn    = regQ[IDX_CTRL][BIT_RUN];
  assign ctl.videoEn  = regQ[IDX_CTRL][BIT_VIDEO];
  assign ctl.cursorEn = regQ[IDX_CTRL][BIT_CURS];
  assign clkSel       = regQ[IDX_CTRL][3:0];
  assign irq          = pendQ && regQ[IDX_CTRL][BIT_INT];

  assign cfg.curFirst    = regQ[IDX_CURF];
  assign cfg.curEnd      = regQ[IDX_CURE];
  assign cfg.hBlankStart = regQ[IDX_HBS];
  assign cfg.hBlankLen   = regQ[IDX_HBL];
  assign cfg.hSyncStart  = regQ[IDX_HSS];
  assign cfg.hSyncEnd    = regQ[IDX_HSE];
  assign cfg.compSyncEnd = regQ[IDX_CSE];
  assign cfg.vBlankStart = {regQ[IDX_VBSH], regQ[IDX_VBSL]};
  assign cfg.vBlankLen   = regQ[IDX_VBL];
  assign cfg.vSyncStart  = regQ[IDX_VSS];
  assign cfg.vSyncEnd    = regQ[IDX_VSE];
  assign cfg.holdFirst   = regQ[IDX_XHF];
  assign cfg.holdEnd     = regQ[IDX_XHE];

endmodule

// File: rtl/rtc_engine.sv
module rtc_engine
  import rtc_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic     clk,
  input  logic     rstN,
  input  rtc_ctl_t ctl,
  input  rtc_cfg_t cfg,
  output logic     hSync,
  output logic     vSync,
  output logic     compSync,
  output logic     blank,
  output logic     cursorHit,
  output logic     xferHold,
  output logic     vbEnter
);

  localparam int HC_W = 9;   // sum of two byte values
  localparam int VL_W = 17;  // 16-bit start plus byte length

  logic            charTick;
  logic [HC_W-1:0] hChar, hTot, hOff;
  logic [VL_W-1:0] vLine, vTot, vOff, nextLine, vbsExt;
  logic            lastChar, lastLine;
  logic            hBlankNow, vBlankNow, hSyncWin, serration;

  // prescaler variant chosen by the character width
  generate
    if (CHAR_W == 1) begin : g_noPre
      assign charTick = ctl.runEn;
    end else begin : g_pre
      localparam int PRE_W = $clog2(CHAR_W);
      logic [PRE_W-1:0] pixCnt;
      always_ff @(posedge clk) begin
        if (!rstN || !ctl.runEn)                 pixCnt <= '0;
        else if (pixCnt == PRE_W'(CHAR_W - 1))   pixCnt <= '0;
        else                                     pixCnt <= pixCnt + 1'b1;
      end
      assign charTick = ctl.runEn && (pixCnt == PRE_W'(CHAR_W - 1));
    end
  endgenerate

  assign hTot     = {1'b0, cfg.hBlankStart} + {1'b0, cfg.hBlankLen};
  assign vbsExt   = {1'b0, cfg.vBlankStart};
  assign vTot     = vbsExt + {9'd0, cfg.vBlankLen};
  assign lastChar = (hChar + 1'b1) >= hTot;
  assign lastLine = (vLine + 1'b1) >= vTot;
  assign nextLine = lastLine ? '0 : vLine + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN || !ctl.runEn) begin
      hChar <= '0;
      vLine <= '0;
    end else if (charTick) begin
      if (lastChar) begin
        hChar <= '0;
        vLine <= nextLine;
      end else begin
        hChar <= hChar + 1'b1;
      end
    end
  end

  assign vbEnter = charTick && lastChar && (nextLine == vbsExt);

  assign hBlankNow = hChar >= {1'b0, cfg.hBlankStart};
  assign hOff      = hChar - {1'b0, cfg.hBlankStart};
  assign vBlankNow = vLine >= vbsExt;
  assign vOff      = vLine - vbsExt;

  assign hSyncWin  = hBlankNow && (hOff >= {1'b0, cfg.hSyncStart}) &&
                     (hOff < {1'b0, cfg.hSyncEnd});
  assign serration = hBlankNow && (hOff >= {1'b0, cfg.hSyncStart}) &&
                     (hOff < {1'b0, cfg.compSyncEnd});

  assign hSync = ctl.runEn && hSyncWin;
  assign vSync = ctl.runEn && vBlankNow && (vOff >= {9'd0, cfg.vSyncStart}) &&
                 (vOff < {9'd0, cfg.vSyncEnd});
  assign compSync = vSync ? !serration : hSync;

  assign blank = !ctl.runEn || !ctl.videoEn || hBlankNow || vBlankNow;

  assign cursorHit = ctl.runEn && ctl.cursorEn && !hBlankNow && !vBlankNow &&
                     (hChar >= {1'b0, cfg.curFirst}) && (hChar < {1'b0, cfg.curEnd});

  assign xferHold = ctl.runEn && (hChar >= {1'b0, cfg.holdFirst}) &&
                    (hChar < {1'b0, cfg.holdEnd});

endmodule

// File: rtl/raster_timing_ctrl.sv
module raster_timing_ctrl
  import rtc_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int REG_BASE = 16,
  parameter int CHAR_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  input  logic [3:0]        monId,
  input  logic [2:0]        monRes,
  output logic              hSync,
  output logic              vSync,
  output logic              compSync,
  output logic              blank,
  output logic              cursorHit,
  output logic              xferHold,
  output logic              irq,
  output logic [3:0]        clkSel
);

  rtc_ctl_t ctlS;
  rtc_cfg_t cfgS;
  logic     vbEnter;

  rtc_regs #(.ADDR_W(ADDR_W), .REG_BASE(REG_BASE)) ctrlI (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .monId(monId), .monRes(monRes),
    .vbEnter(vbEnter), .ctl(ctlS), .cfg(cfgS), .clkSel(clkSel), .irq(irq)
  );

  rtc_engine #(.CHAR_W(CHAR_W)) dpI (
    .clk(clk), .rstN(rstN), .ctl(ctlS), .cfg(cfgS),
    .hSync(hSync), .vSync(vSync), .compSync(compSync), .blank(blank),
    .cursorHit(cursorHit), .xferHold(xferHold), .vbEnter(vbEnter)
  );

endmodule

// File: rtl/rtc_checker.sv
module rtc_checker
  import rtc_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int STAT_ADDR = 17
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic              hSync,
  input logic              vSync,
  input logic              blank,
  input logic              irq,
  input rtc_ctl_t          ctl
);

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.runEn |-> (!hSync && !vSync && blank));

  // R7
  video_off_blank_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.videoEn |-> blank);

  // R5
  hsync_in_blank_chk: assert property (@(posedge clk) disable iff (!rstN)
    hSync |-> blank);

  // R6
  vsync_in_blank_chk: assert property (@(posedge clk) disable iff (!rstN)
    vSync |-> blank);

  // R8
  status_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_W'(STAT_ADDR)) |=> !irq);

  // R8
  irq_at_blank_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> blank);

endmodule

bind raster_timing_ctrl rtc_checker #(.ADDR_W(ADDR_W), .STAT_ADDR(REG_BASE + 1)) chkI (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
  .hSync(hSync), .vSync(vSync), .blank(blank), .irq(irq), .ctl(ctlS)
);

// File: tb/raster_timing_ctrl_test.sv
module raster_timing_ctrl_test;

  localparam int CW = 2;
  localparam int HBS = 10, HBL = 4, HSS = 1, HSE = 3, CSE = 2;
  localparam int VBS = 6, VBL = 3, VSS = 1, VSE = 2;
  localparam int CF = 2, CE = 5, XF = 7, XE = 9;
  localparam int HT = HBS + HBL;
  localparam int VT = VBS + VBL;
  localparam int FRAME = HT * VT * CW;
  localparam logic [7:0] MON_STAT = 8'h41;  // res 4, id 1

  // {address, write data, expected readback}
  localparam int NV = 17;
  localparam logic [20:0] VEC [NV] = '{
    {5'h12, 8'd2,  8'd2},  {5'h13, 8'd5,  8'd5},  {5'h14, 8'd10, 8'd10},
    {5'h15, 8'd4,  8'd4},  {5'h16, 8'd1,  8'd1},  {5'h17, 8'd3,  8'd3},
    {5'h18, 8'd2,  8'd2},  {5'h19, 8'd0,  8'd0},  {5'h1A, 8'd6,  8'd6},
    {5'h1B, 8'd3,  8'd3},  {5'h1C, 8'd1,  8'd1},  {5'h1D, 8'd2,  8'd2},
    {5'h1E, 8'd7,  8'd7},  {5'h1F, 8'd9,  8'd9},  {5'h11, 8'hFF, MON_STAT},
    {5'h05, 8'hAA, 8'h00}, {5'h10, 8'h0F, 8'h0F}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] busAddr = '0;
  logic       busWe = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic [3:0] monId = 4'd1;
  logic [2:0] monRes = 3'd4;
  logic       hSync, vSync, compSync, blank, cursorHit, xferHold, irq;
  logic [3:0] clkSel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  raster_timing_ctrl #(.ADDR_W(5), .REG_BASE(16), .CHAR_W(CW)) uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .monId(monId), .monRes(monRes),
    .hSync(hSync), .vSync(vSync), .compSync(compSync), .blank(blank),
    .cursorHit(cursorHit), .xferHold(xferHold), .irq(irq), .clkSel(clkSel)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // expected outputs at k clocks after the timing engine is switched on
  task automatic model(input int k, input bit ven, input bit cen,
                       output bit hs, output bit vs, output bit cs,
                       output bit bl, output bit cur, output bit xf);
    int c, ln, ho, vo;
    bit hb, vb, ser;
    c  = (k / CW) % HT;
    ln = (k / (CW * HT)) % VT;
    hb = c >= HBS;  ho = c - HBS;
    vb = ln >= VBS; vo = ln - VBS;
    hs = hb && ho >= HSS && ho < HSE;
    vs = vb && vo >= VSS && vo < VSE;
    ser = hb && ho >= HSS && ho < CSE;
    cs = vs ? !ser : hs;
    bl = !ven || hb || vb;
    cur = cen && !hb && !vb && c >= CF && c < CE;
    xf = c >= XF && c < XE;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [7:0] d;
    bit hs, vs, cs, bl, cur, xf;
    int seen;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R3 reset state
    rd(5'h10, d); chk("R3 control after reset", d, 0);
    rd(5'h14, d); chk("R3 timing reg after reset", d, 0);
    chk("R3 blank", blank, 1);
    chk("R3 hSync", hSync, 0);
    chk("R3 vSync", vSync, 0);
    chk("R3 compSync", compSync, 0);
    chk("R3 irq", irq, 0);
    rd(5'h11, d); chk("R2 status after reset", d, MON_STAT);

    // R1 R2 R12 register table
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][20:16], VEC[i][15:8]);
      rd(VEC[i][20:16], d);
      chk("R1 readback", d, VEC[i][7:0]);
    end
    chk("R12 clkSel", clkSel, 4'hF);

    // R2 pins change later: no effect
    monId = 4'd3; monRes = 3'd6;
    repeat (3) @(negedge clk);
    rd(5'h11, d); chk("R2 late pin change", d, MON_STAT);

    // R5 R6 R7 R8 R9 R10 R11 two full frames, everything enabled
    wr(5'h10, 8'hF5);
    for (int k = 0; k < 2 * FRAME; k++) begin
      model(k, 1'b1, 1'b1, hs, vs, cs, bl, cur, xf);
      chk("R5 hSync", hSync, hs);
      chk("R6 vSync", vSync, vs);
      chk("R9 compSync", compSync, cs);
      chk("R7 blank", blank, bl);
      chk("R10 cursorHit", cursorHit, cur);
      chk("R11 xferHold", xferHold, xf);
      chk("R8 irq", irq, (k >= VBS * HT * CW) ? 1 : 0);
      @(negedge clk);
    end
    chk("R12 clkSel run", clkSel, 4'h5);
    rd(5'h11, d); chk("R8 pending in status", d, {1'b1, MON_STAT[6:0]});

    // R8 status write clears
    wr(5'h11, 8'h00);
    chk("R8 irq cleared", irq, 0);
    rd(5'h11, d); chk("R8 status cleared", d, MON_STAT);

    // R7 video off keeps the other bits and the raster
    wr(5'h10, 8'hB5);
    rd(5'h10, d); chk("R7 control kept", d, 8'hB5);
    seen = 0;
    for (int k = 0; k < 2 * HT * CW; k++) begin
      chk("R7 blank video off", blank, 1);
      if (hSync) seen++;
      @(negedge clk);
    end
    chk("R7 raster still running", (seen > 0) ? 1 : 0, 1);

    // R4 timing disabled
    wr(5'h10, 8'h00);
    for (int k = 0; k < 2 * HT * CW; k++) begin
      chk("R4 hSync idle", hSync, 0);
      chk("R4 vSync idle", vSync, 0);
      chk("R4 blank idle", blank, 1);
      chk("R4 xferHold idle", xferHold, 0);
      @(negedge clk);
    end

    // R8 interrupt disabled: no pending
    wr(5'h10, 8'h60);
    for (int k = 0; k < FRAME; k++) begin
      chk("R8 irq masked", irq, 0);
      @(negedge clk);
    end
    rd(5'h11, d); chk("R8 no pending when masked", d, MON_STAT);

    // R6 high byte of vertical blank start: start = 256
    wr(5'h10, 8'h00);
    wr(5'h19, 8'h01);
    wr(5'h1A, 8'h00);
    wr(5'h10, 8'h60);
    repeat (255 * HT * CW) @(negedge clk);
    chk("R6 line 255 visible", blank, 0);
    repeat (HT * CW) @(negedge clk);
    chk("R6 line 256 blanked", blank, 1);
    chk("R6 line 256 no vsync", vSync, 0);
    repeat (HT * CW + 2 * CW) @(negedge clk);
    chk("R6 line 257 vsync", vSync, 1);

    finishRun();
  end

endmodule